// File: doc/BRIEF.md
# Store Byte-Lane Write Network

This block sits between a processor's store path and a 32-bit memory that has one independent write enable per byte. It takes a byte address, a two-bit operand size, a write request and the store data. It produces the word address, a data bus on which the operand is copied into every lane it could land in, four lane write enables and a fault flag for stores the memory cannot take in one word cycle.

Lane selection is left entirely to the write enables. A byte is copied into all four lanes, and a halfword into both halves, so the data path is a fixed fan-out with no shifter. The low address bits and the size then decide which enables fire. A halfword at an odd address, a word at any address that is not a multiple of four, and the reserved size code raise the fault. In those cases no lane is written.

All outputs are registered once, so the result of a request shows up one clock after it is presented.

Top module: `store_lane_writer`

## Requirements
- R1: Every output is updated one clock after its inputs are sampled. While rst_n is low, mem_wstrb is 0, wr_fault is 0, and mem_addr and mem_wdata are 0.
- R2: mem_addr equals the byte address shifted right by two bits, for every request whether or not it writes.
- R3: With size code 0 (byte), mem_wdata holds four copies of data bits [7:0]. With a write, exactly one strobe is set: bit n of mem_wstrb, where n is address bits [1:0].
- R4: With size code 1 (halfword), mem_wdata holds two copies of data bits [15:0]. An even-address write sets mem_wstrb to 4'b0011 when address bit 1 is 0 and to 4'b1100 when address bit 1 is 1.
- R5: With size code 2 (word), mem_wdata equals the store data unchanged. A write with address bits [1:0] equal to 0 sets mem_wstrb to 4'b1111.
- R6: wr_fault is set for a write when any of these holds: the size is 1 and address bit 0 is 1; the size is 2 and address bits [1:0] are not 0; the size code is 3. It is never set without a write.
- R7: When wr_fault is set, or when no write is requested, mem_wstrb is 4'b0000.
- R8: With size code 3, mem_wdata equals the store data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Byte address of the store |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| cpu_wr | input | 1 | Write request |
| cpu_wdata | input | 32 | Store operand, right-justified |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Lane-replicated data |
| mem_wstrb | output | 4 | Per-byte write enables |
| wr_fault | output | 1 | Misaligned or reserved-size store |

## Verification
The hardest behaviour to reach is the suppression of lane enables on a store that is both requested and faulted. This happens only for specific pairings of size code and low address bits, and a skewed random mix rarely lands on each of them. The stimulus therefore sweeps every combination of size code, two low address bits and write request, with data patterns that differ per byte. After that sweep comes a long random run whose random data makes any lane mix-up visible.

// File: rtl/store_lane_writer.sv
module store_lane_writer #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_wr,
  input  logic [31:0]       cpu_wdata,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  output logic              wr_fault
);

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  logic [1:0]  ofs;
  logic        bad;
  logic [31:0] rep;
  logic [3:0]  lanes;

  assign ofs = cpu_addr[1:0];

  assign bad = (cpu_size == SZ_H && ofs[0]) ||
               (cpu_size == SZ_W && ofs != 2'd0) ||
               (cpu_size == 2'd3);

  always_comb begin
    case (cpu_size)
      SZ_B:    rep = {4{cpu_wdata[7:0]}};
      SZ_H:    rep = {2{cpu_wdata[15:0]}};
      default: rep = cpu_wdata;
    endcase
  end

  always_comb begin
    case (cpu_size)
      SZ_B:    lanes = 4'b0001 << ofs;
      SZ_H:    lanes = ofs[1] ? 4'b1100 : 4'b0011;
      SZ_W:    lanes = 4'b1111;
      default: lanes = 4'b0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wstrb <= '0;
      wr_fault  <= 1'b0;
    end else begin
      mem_addr  <= cpu_addr[ADDR_W-1:2];
      mem_wdata <= rep;
      mem_wstrb <= (cpu_wr && !bad) ? lanes : 4'b0000;
      wr_fault  <= cpu_wr && bad;
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> mem_wstrb == 4'b0000);

  // R6
  fault_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(cpu_wr)) |-> !wr_fault && mem_wstrb == 4'b0000);

  // R3
  byte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cpu_wr) && $past(cpu_size) == 2'd0) |-> $countones(mem_wstrb) == 1);

  // R4
  half_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cpu_size) == 2'd1) |-> mem_wdata[31:16] == mem_wdata[15:0]);

  // R5
  word_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cpu_wr) && $past(cpu_size) == 2'd2 && $past(cpu_addr[1:0]) == 2'd0)
      |-> mem_wstrb == 4'b1111 && mem_wdata == $past(cpu_wdata));

  // R2
  addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> mem_addr == $past(cpu_addr[ADDR_W-1:2]));

endmodule

// File: tb/store_lane_writer_bench.sv
module store_lane_writer_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [1:0]    cpu_size = '0;
  logic          cpu_wr = 1'b0;
  logic [31:0]   cpu_wdata = '0;
  logic [AW-3:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [3:0]    mem_wstrb;
  logic          wr_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  store_lane_writer #(.ADDR_W(AW)) u_store_lane_writer (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .wr_fault(wr_fault));

  function automatic bit exp_fault(input logic [1:0] sz, input logic [1:0] o, input logic w);
    return w && ((sz == 2'd1 && o[0]) || (sz == 2'd2 && o != 2'd0) || sz == 2'd3);
  endfunction

  function automatic logic [31:0] exp_data(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'd0) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (sz == 2'd1) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [3:0] exp_strb(input logic [1:0] sz, input logic [1:0] o, input logic w);
    logic [3:0] s;
    if (!w || exp_fault(sz, o, w)) return 4'b0000;
    case (sz)
      2'd0: begin s = 4'b0000; s[o] = 1'b1; end
      2'd1: s = o[1] ? 4'b1100 : 4'b0011;
      default: s = 4'b1111;
    endcase
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string data_req(input logic [1:0] sz);
    case (sz)
      2'd0: return "R3 data";
      2'd1: return "R4 data";
      2'd2: return "R5 data";
      default: return "R8 data";
    endcase
  endfunction

  function automatic string strb_req(input logic [1:0] sz, input logic [1:0] o, input logic w);
    if (exp_fault(sz, o, w) || !w) return "R7 strobes";
    case (sz)
      2'd0: return "R3 strobes";
      2'd1: return "R4 strobes";
      default: return "R5 strobes";
    endcase
  endfunction

  task automatic apply(input logic [AW-1:0] a, input logic [1:0] sz, input logic w, input logic [31:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_size = sz; cpu_wr = w; cpu_wdata = d;
    @(posedge clk);
    #2;
    check("R2 address", 32'(mem_addr), 32'(a[AW-1:2]));
    check(data_req(sz), mem_wdata, exp_data(sz, d));
    check(strb_req(sz, a[1:0], w), 32'(mem_wstrb), 32'(exp_strb(sz, a[1:0], w)));
    check("R6 fault", 32'(wr_fault), 32'(exp_fault(sz, a[1:0], w)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset strobes", 32'(mem_wstrb), 32'h0);
    check("R1 reset fault", 32'(wr_fault), 32'h0);
    check("R1 reset data", mem_wdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++)
        for (int w = 0; w < 2; w++)
          apply({28'h1234567, 2'b10, 2'(o)}, 2'(sz), 1'(w), 32'hA1B2C3D4);
    apply('0, 2'd2, 1'b1, 32'hFFFFFFFF);
    apply('1, 2'd0, 1'b1, 32'h000000EE);
    apply('1, 2'd3, 1'b1, 32'h5A5A5A5A);
    begin
      int unsigned seed_hold;
      seed_hold = $urandom(32'd20240611);
    end
    for (int i = 0; i < 3000; i++)
      apply($urandom, 2'($urandom), 1'($urandom), $urandom);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    check("R1 reset again strobes", 32'(mem_wstrb), 32'h0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule